// File: doc/BRIEF.md
# Shadow Memory Attribute Decoder

This block sits inside a host bridge and holds a 256-byte configuration register file, reached through a byte-wide port that carries a function number, a register offset and data. Seven of those bytes are attribute registers. Each 4-bit nibble of them governs one fixed window of the upper-memory area, C0000h to FFFFFh, and says for reads and writes separately whether an access is served by internal DRAM or passed to the external bus, where the ROMs live.

For every memory access the block takes the 20-bit address and a direction bit and returns one routing bit. The result is purely combinational from the address, the direction and the current register contents. A separate output shows whether the BIOS window is shadowed. Identification and class bytes are fixed constants. Every other byte can be read back exactly as it was written.

Top module: `shadow_attr_decoder`

## Requirements
- R1: Only function 0 exists. A write with a non-zero function number changes no register, and a read with a non-zero function number returns 0xFF.
- R2: Offsets 0x00–0x03, 0x08–0x0B and 0x0E are constant and ignore writes. They hold 0x86, 0x80, 0xA3, 0x04 at 0x00–0x03, 0x03 at 0x08, 0x00 at 0x09, 0x0A and 0x0E, and 0x06 at 0x0B.
- R3: A function-0 write to any other offset stores the byte on the next rising clock edge. A read in the same cycle as the write returns the previous value, and later reads return the new value.
- R4: After reset, offset 0x04 holds 0x06, 0x07 holds 0x02, 0x50 holds 0x80, 0x52 holds 0x40, 0x57 holds 0x31, 0x60–0x64 hold 0x02, and every other writable byte holds 0x00. In that state every access in C0000h–FFFFFh routes to the external bus.
- R5: In an attribute nibble, bit 0 set routes reads to internal memory and bit 1 set routes writes to internal memory. A clear bit routes that direction to the external bus. The output `route_internal` is 1 for internal and 0 for external.
- R6: The high nibble of offset 0x59 controls the 64 KB window F0000h–FFFFFh. The low nibble of 0x59 has no effect on routing.
- R7: Offsets 0x5A–0x5F each control two adjacent 16 KB windows: the low nibble controls the lower window and the high nibble the upper one. In ascending order they cover C0000h–EFFFFh, so 0x5A covers C0000h/C4000h and 0x5F covers E8000h/EC000h.
- R8: Addresses below C0000h route to internal memory for both reads and writes, whatever the registers hold.
- R9: `bios_shadowed` equals bit 4 of offset 0x59.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_func | input | 3 | Function number of the configuration access |
| cfg_off | input | 8 | Register offset |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_func/cfg_off (combinational) |
| mem_addr | input | 20 | Memory access address |
| mem_is_write | input | 1 | 1 for a write access, 0 for a read access |
| route_internal | output | 1 | 1 routes the access to internal DRAM, 0 to the external bus |
| bios_shadowed | output | 1 | BIOS window shadow flag |

## Verification
The write-then-read property assumes that the configuration inputs are quiet (write strobe low) while reset is asserted and during the two-cycle internal reset release. Otherwise the cycle before an observed read could hold a write that the still-reset register file dropped. The bench keeps the strobe low until well after release. It changes the function, offset, write data and address only on falling edges and holds each write for exactly one rising edge. The cross-check between the BIOS flag and read routing in the F0000h window relies on the address being stable over the sampled cycle, which the falling-edge driving guarantees.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;
  localparam int unsigned NREG      = 256;
  localparam int unsigned OFF_W     = $clog2(NREG);
  localparam int unsigned BIOS_OFF  = 8'h59;
  localparam int unsigned OPT_OFF   = 8'h5A;
  localparam int unsigned OPT_REGS  = 6;

  typedef logic [7:0] byte_t;

  function automatic logic is_fixed(input logic [7:0] off);
    return (off <= 8'h03) || (off >= 8'h08 && off <= 8'h0B) || (off == 8'h0E);
  endfunction

  function automatic byte_t reset_byte(input logic [7:0] off);
    byte_t v;
    case (off)
      8'h00: v = 8'h86;
      8'h01: v = 8'h80;
      8'h02: v = 8'hA3;
      8'h03: v = 8'h04;
      8'h04: v = 8'h06;
      8'h07: v = 8'h02;
      8'h08: v = 8'h03;
      8'h0B: v = 8'h06;
      8'h50: v = 8'h80;
      8'h52: v = 8'h40;
      8'h57: v = 8'h31;
      8'h60, 8'h61, 8'h62, 8'h63, 8'h64: v = 8'h02;
      default: v = 8'h00;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/shadow_rst_sync.sv
module shadow_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  byte_t            wr_data,
  input  logic [OFF_W-1:0] rd_off,
  output byte_t            rd_data,
  output byte_t            regs [NREG]
);
  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_byte
      if (is_fixed(gi[7:0])) begin : g_const
        assign regs[gi] = reset_byte(gi[7:0]);
      end else begin : g_store
        byte_t val_q;
        byte_t val_d;
        logic  hit;
        assign hit = wr_en && (wr_off == gi[OFF_W-1:0]);
        always_comb val_d = hit ? wr_data : val_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) val_q <= reset_byte(gi[7:0]);
          else        val_q <= val_d;
        end
        assign regs[gi] = val_q;
      end
    end
  endgenerate

  assign rd_data = regs[rd_off];
endmodule

// File: rtl/shadow_region_decode.sv
module shadow_region_decode
  import shadow_attr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned SEG_SHIFT = 14
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  byte_t             bios_attr,
  input  byte_t             opt_attr [OPT_REGS],
  output logic              internal
);
  localparam int unsigned TOP_W   = ADDR_W - SEG_SHIFT;
  localparam int unsigned OPT_SEGS = 2 * OPT_REGS;
  localparam logic [TOP_W-1:0] OPT_BASE = TOP_W'(12 << (TOP_W - 4));
  localparam logic [TOP_W-1:0] BIOS_BASE = TOP_W'(15 << (TOP_W - 4));

  logic [TOP_W-1:0] seg;
  logic [TOP_W-1:0] rel;
  logic [3:0]       nib;
  logic             in_bios;
  logic             in_opt;

  always_comb begin
    seg     = addr[ADDR_W-1:SEG_SHIFT];
    rel     = seg - OPT_BASE;
    in_bios = (seg >= BIOS_BASE);
    in_opt  = (seg >= OPT_BASE) && (rel < TOP_W'(OPT_SEGS));
    nib     = 4'h0;
    if (in_bios) begin
      nib = bios_attr[7:4];
    end else if (in_opt) begin
      nib = rel[0] ? opt_attr[rel[TOP_W-1:1]][7:4] : opt_attr[rel[TOP_W-1:1]][3:0];
    end
    if (in_bios || in_opt) internal = is_write ? nib[1] : nib[0];
    else                   internal = 1'b1;
  end
endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
  import shadow_attr_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned FUNC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FUNC_W-1:0] cfg_func,
  input  logic [7:0]        cfg_off,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_is_write,
  output logic              route_internal,
  output logic              bios_shadowed
);
  logic  rst_n_int;
  logic  func0;
  logic  wr_ok;
  byte_t rd_raw;
  byte_t regs [NREG];
  byte_t opt_attr [OPT_REGS];

  shadow_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  assign func0 = (cfg_func == '0);
  assign wr_ok = cfg_we && func0;

  shadow_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n_int),
    .wr_en(wr_ok), .wr_off(cfg_off), .wr_data(cfg_wdata),
    .rd_off(cfg_off), .rd_data(rd_raw), .regs(regs)
  );

  genvar gk;
  generate
    for (gk = 0; gk < OPT_REGS; gk++) begin : g_opt
      assign opt_attr[gk] = regs[OPT_OFF + gk];
    end
  endgenerate

  shadow_region_decode #(.ADDR_W(ADDR_W), .SEG_SHIFT(14)) u_dec (
    .addr(mem_addr), .is_write(mem_is_write),
    .bios_attr(regs[BIOS_OFF]), .opt_attr(opt_attr),
    .internal(route_internal)
  );

  assign cfg_rdata     = func0 ? rd_raw : 8'hFF;
  assign bios_shadowed = regs[BIOS_OFF][4];
endmodule

// File: rtl/shadow_attr_checker.sv
module shadow_attr_checker
  import shadow_attr_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned FUNC_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FUNC_W-1:0] cfg_func,
  input logic [7:0]        cfg_off,
  input logic              cfg_we,
  input logic [7:0]        cfg_wdata,
  input logic [7:0]        cfg_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_is_write,
  input logic              route_internal,
  input logic              bios_shadowed
);
  // R1
  other_func_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_func != '0) |-> (cfg_rdata == 8'hFF));

  // R2
  fixed_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_func == '0 && is_fixed(cfg_off)) |-> (cfg_rdata == reset_byte(cfg_off)));

  // R3
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_func == '0 && !is_fixed(cfg_off))
    |=> ((cfg_func == '0 && cfg_off == $past(cfg_off)) -> (cfg_rdata == $past(cfg_wdata))));

  // R8
  low_mem_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[ADDR_W-1:ADDR_W-2] != 2'b11) |-> route_internal);

  // R9
  bios_flag_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr[ADDR_W-1:ADDR_W-4] == 4'hF && !mem_is_write) |-> (route_internal == bios_shadowed));
endmodule

bind shadow_attr_decoder shadow_attr_checker #(.ADDR_W(ADDR_W), .FUNC_W(FUNC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_off(cfg_off), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
  .mem_is_write(mem_is_write), .route_internal(route_internal), .bios_shadowed(bios_shadowed)
);

// File: tb/shadow_attr_decoder_test.sv
`timescale 1ns/1ps
module shadow_attr_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_func;
  logic [7:0]  cfg_off;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [19:0] mem_addr;
  logic        mem_is_write;
  logic        route_internal;
  logic        bios_shadowed;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shadow_attr_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_off(cfg_off), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .mem_is_write(mem_is_write), .route_internal(route_internal), .bios_shadowed(bios_shadowed)
  );

  // {addr[19:0], is_write, expected route_internal} after programming:
  // 0x59=0x35, 0x5A=0x21, 0x5C=0x12, 0x5F=0x03
  localparam int NV = 20;
  localparam logic [21:0] VEC [NV] = '{
    {20'hC0000, 1'b0, 1'b1}, {20'hC0000, 1'b1, 1'b0},
    {20'hC3FFF, 1'b0, 1'b1}, {20'hC4000, 1'b0, 1'b0},
    {20'hC7FFF, 1'b1, 1'b1}, {20'hC8000, 1'b0, 1'b0},
    {20'hD0000, 1'b0, 1'b0}, {20'hD0000, 1'b1, 1'b1},
    {20'hD4000, 1'b0, 1'b1}, {20'hD7FFF, 1'b1, 1'b0},
    {20'hE8000, 1'b0, 1'b1}, {20'hEBFFF, 1'b1, 1'b1},
    {20'hEC000, 1'b0, 1'b0}, {20'hEFFFF, 1'b1, 1'b0},
    {20'hF0000, 1'b0, 1'b1}, {20'hFFFFF, 1'b1, 1'b1},
    {20'hBFFFF, 1'b0, 1'b1}, {20'hBFFFF, 1'b1, 1'b1},
    {20'h00000, 1'b1, 1'b1}, {20'h9F000, 1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] f, input logic [7:0] o, input logic [7:0] d);
    @(negedge clk);
    cfg_func = f; cfg_off = o; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_func = 3'd0;
  endtask

  task automatic rd_chk(input logic [2:0] f, input logic [7:0] o, input logic [7:0] e, input string req);
    @(negedge clk);
    cfg_func = f; cfg_off = o;
    #1;
    check(cfg_rdata == e, req, cfg_rdata, e);
    cfg_func = 3'd0;
  endtask

  task automatic route_chk(input logic [19:0] a, input logic w, input logic e, input string req);
    @(negedge clk);
    mem_addr = a; mem_is_write = w;
    #1;
    check(route_internal == e, req, route_internal, e);
  endtask

  initial begin
    rst_n = 1'b0; cfg_func = 3'd0; cfg_off = 8'h00; cfg_we = 1'b0; cfg_wdata = 8'h00;
    mem_addr = 20'h00000; mem_is_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 reset state
    rd_chk(3'd0, 8'h50, 8'h80, "R4");
    rd_chk(3'd0, 8'h52, 8'h40, "R4");
    rd_chk(3'd0, 8'h57, 8'h31, "R4");
    rd_chk(3'd0, 8'h60, 8'h02, "R4");
    rd_chk(3'd0, 8'h64, 8'h02, "R4");
    rd_chk(3'd0, 8'h04, 8'h06, "R4");
    rd_chk(3'd0, 8'h59, 8'h00, "R4");
    route_chk(20'hF0000, 1'b0, 1'b0, "R4");
    route_chk(20'hC0000, 1'b1, 1'b0, "R4");
    route_chk(20'hE4000, 1'b0, 1'b0, "R4");
    check(bios_shadowed == 1'b0, "R9", bios_shadowed, 0);

    // R2 fixed bytes and discarded writes
    rd_chk(3'd0, 8'h00, 8'h86, "R2");
    rd_chk(3'd0, 8'h02, 8'hA3, "R2");
    rd_chk(3'd0, 8'h08, 8'h03, "R2");
    rd_chk(3'd0, 8'h0B, 8'h06, "R2");
    wr(3'd0, 8'h00, 8'h55);
    rd_chk(3'd0, 8'h00, 8'h86, "R2");
    wr(3'd0, 8'h0E, 8'hAA);
    rd_chk(3'd0, 8'h0E, 8'h00, "R2");

    // R1 other functions
    wr(3'd1, 8'h59, 8'h33);
    rd_chk(3'd0, 8'h59, 8'h00, "R1");
    route_chk(20'hF8000, 1'b0, 1'b0, "R1");
    rd_chk(3'd2, 8'h50, 8'hFF, "R1");

    // R3 no bypass: same-cycle read shows old value, next cycle new
    @(negedge clk);
    cfg_func = 3'd0; cfg_off = 8'h40; cfg_wdata = 8'hC3; cfg_we = 1'b1;
    #1;
    check(cfg_rdata == 8'h00, "R3", cfg_rdata, 8'h00);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check(cfg_rdata == 8'hC3, "R3", cfg_rdata, 8'hC3);

    // R6 low nibble of 0x59 has no effect; R9 flag
    wr(3'd0, 8'h59, 8'h0F);
    route_chk(20'hF0000, 1'b0, 1'b0, "R6");
    route_chk(20'hF0000, 1'b1, 1'b0, "R6");
    check(bios_shadowed == 1'b0, "R9", bios_shadowed, 0);
    route_chk(20'hC0000, 1'b0, 1'b0, "R6");

    // R5 R7 table
    wr(3'd0, 8'h59, 8'h35);
    wr(3'd0, 8'h5A, 8'h21);
    wr(3'd0, 8'h5C, 8'h12);
    wr(3'd0, 8'h5F, 8'h03);
    check(bios_shadowed == 1'b1, "R9", bios_shadowed, 1);
    for (int i = 0; i < NV; i++) begin
      route_chk(VEC[i][21:2], VEC[i][1], VEC[i][0],
                (VEC[i][21:20] != 2'b11) ? "R8" : "R5_R7");
    end

    // R5 write-only shadow of BIOS window
    wr(3'd0, 8'h59, 8'h20);
    route_chk(20'hF4000, 1'b0, 1'b0, "R5");
    route_chk(20'hF4000, 1'b1, 1'b1, "R5");
    check(bios_shadowed == 1'b0, "R9", bios_shadowed, 0);

    // R4 reset again restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk(3'd0, 8'h5A, 8'h00, "R4");
    rd_chk(3'd0, 8'h40, 8'h00, "R4");

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule